// File: doc/BRIEF.md
# Floating-Point Rounding Stage

This block takes an unrounded single-precision result and fits it into a 24-bit significand. Its inputs are a sign, a biased exponent, the significand with two extra low-order bits (guard and round), and a sticky bit that is the OR of everything shifted out below the round bit. A 2-bit mode input selects one of four rounding directions, all of which act on the sign-magnitude value. The block is placed after an adder or a format converter that has already normalized its result.

The rounding decision and the increment are combinational. One output register holds the rounded sign, exponent, significand and an overflow flag, so results appear one clock after their inputs. When the increment carries out of the significand, the result is renormalized: the significand becomes 1.000…0 and the exponent goes up by one. The overflow flag is raised when the rounded exponent is all ones.

Top module: `fp_round_stage`

## Requirements
- R1: While rst_n is low, sign_o, exp_o, sig_o and ovf_o are all zero.
- R2: Outputs are registered. The values presented on one rising edge appear after that edge, and sign_o equals the sampled sign_i.
- R3: Mode 2'b01 (toward zero) never increments. sig_o is sig_i[25:2] and exp_o is exp_i.
- R4: Mode 2'b10 (toward plus infinity) increments the magnitude only for a positive value with any of guard sig_i[1], round sig_i[0] or sticky_i set. Negative values are truncated.
- R5: Mode 2'b11 (toward minus infinity) increments the magnitude only for a negative value with any discarded bit set. Positive values are truncated.
- R6: Mode 2'b00 (nearest even, the default when the mode input is held at zero) truncates when guard is 0. It increments when guard is 1 and round or sticky is 1.
- R7: In mode 2'b00, an exact tie (guard 1, round 0, sticky 0) increments only when the significand LSB sig_i[2] is 1, so the result is always even.
- R8: When guard, round and sticky are all zero, the significand and exponent pass through unchanged in every mode.
- R9: When the increment carries out of the 24-bit significand, sig_o is 24'h800000 and exp_o is exp_i + 1.
- R10: ovf_o is 1 exactly when the rounded exponent exp_o equals 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Rounding mode: 00 nearest even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| sign_i | input | 1 | Sign of the value (1 = negative) |
| exp_i | input | 8 | Biased exponent |
| sig_i | input | 26 | Significand [25:2], guard [1], round [0] |
| sticky_i | input | 1 | OR of all bits shifted out below round |
| sign_o | output | 1 | Registered sign |
| exp_o | output | 8 | Registered rounded exponent |
| sig_o | output | 24 | Registered rounded significand |
| ovf_o | output | 1 | Rounded exponent reached all ones |

## Verification
The checks assume that the exponent input is never already all ones, so the renormalizing increment cannot wrap the exponent field. They also assume that sticky_i really is the OR of the lower discarded bits, because the tie check treats guard=1 with round=sticky=0 as an exact half. All stimulus keeps the exponent in the range 1 to 254 and holds the significand normalized (MSB set). Carry-out cases are driven only with an all-ones significand, and the only exponent that reaches overflow is 254.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } rnd_mode_e;

  // Decide whether the magnitude gets one unit in the last place.
  function automatic logic rnd_bump(rnd_mode_e m, logic neg, logic lsb,
                                    logic guard, logic rest);
    logic dropped;
    dropped = guard | rest;
    unique case (m)
      RM_NEAREST: return guard & (rest | lsb);
      RM_ZERO:    return 1'b0;
      RM_UP:      return ~neg & dropped;
      RM_DOWN:    return neg & dropped;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fp_round_decide.sv
module fp_round_decide
  import fp_round_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       neg,
  input  logic       lsb,
  input  logic       guard,
  input  logic       round_bit,
  input  logic       sticky,
  output logic       bump,
  output logic       tie,
  output logic       dropped_nz
);
  logic rest;

  always_comb begin
    rest       = round_bit | sticky;
    dropped_nz = guard | rest;
    tie        = guard & ~rest;
    bump       = rnd_bump(rnd_mode_e'(mode), neg, lsb, guard, rest);
  end
endmodule

// File: rtl/fp_round_incr.sv
module fp_round_incr #(
  parameter int SIG_W = 24,
  parameter int EXP_W = 8
) (
  input  logic [SIG_W-1:0] sig,
  input  logic [EXP_W-1:0] expo,
  input  logic             bump,
  output logic [SIG_W-1:0] sig_r,
  output logic [EXP_W-1:0] exp_r,
  output logic             carry
);
  logic [SIG_W:0] sum;

  always_comb begin
    sum   = {1'b0, sig} + {{SIG_W{1'b0}}, bump};
    carry = sum[SIG_W];
    if (carry) begin
      sig_r = sum[SIG_W:1];
      exp_r = expo + {{(EXP_W-1){1'b0}}, 1'b1};
    end else begin
      sig_r = sum[SIG_W-1:0];
      exp_r = expo;
    end
  end
endmodule

// File: rtl/fp_round_stage.sv
module fp_round_stage #(
  parameter int SIG_W = 24,
  parameter int EXP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_i,
  input  logic               sign_i,
  input  logic [EXP_W-1:0]   exp_i,
  input  logic [SIG_W+1:0]   sig_i,
  input  logic               sticky_i,
  output logic               sign_o,
  output logic [EXP_W-1:0]   exp_o,
  output logic [SIG_W-1:0]   sig_o,
  output logic               ovf_o
);
  localparam int FULL_W = SIG_W + 2;

  logic [SIG_W-1:0] sig_trunc;
  logic             round_inc;
  logic             tie_seen;
  logic             dropped_nz;
  logic             carry_out;
  logic [SIG_W-1:0] sig_next;
  logic [EXP_W-1:0] exp_next;
  logic             ovf_next;

  assign sig_trunc = sig_i[FULL_W-1:2];

  fp_round_decide u_decide (
    .mode       (mode_i),
    .neg        (sign_i),
    .lsb        (sig_i[2]),
    .guard      (sig_i[1]),
    .round_bit  (sig_i[0]),
    .sticky     (sticky_i),
    .bump       (round_inc),
    .tie        (tie_seen),
    .dropped_nz (dropped_nz)
  );

  fp_round_incr #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_incr (
    .sig   (sig_trunc),
    .expo  (exp_i),
    .bump  (round_inc),
    .sig_r (sig_next),
    .exp_r (exp_next),
    .carry (carry_out)
  );

  assign ovf_next = &exp_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_o <= 1'b0;
      exp_o  <= '0;
      sig_o  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      sign_o <= sign_i;
      exp_o  <= exp_next;
      sig_o  <= sig_next;
      ovf_o  <= ovf_next;
    end
  end
endmodule

// File: rtl/fp_round_stage_checker.sv
module fp_round_stage_checker #(
  parameter int SIG_W = 24,
  parameter int EXP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             sign_i,
  input logic [EXP_W-1:0] exp_i,
  input logic [SIG_W+1:0] sig_i,
  input logic             sticky_i,
  input logic             sign_o,
  input logic [EXP_W-1:0] exp_o,
  input logic [SIG_W-1:0] sig_o,
  input logic             ovf_o,
  input logic             round_inc,
  input logic             tie_seen,
  input logic             carry_out
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (sig_o == '0 && exp_o == '0 && !ovf_o && !sign_o));

  assert_sign_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> sign_o == $past(sign_i));

  assert_trunc_noinc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 2'b01 |-> !round_inc);

  assert_up_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && sign_i) |-> !round_inc);

  assert_down_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11 && !sign_i) |-> !round_inc);

  assert_tie_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 && tie_seen) |-> (round_inc == sig_i[2]));

  assert_exact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_i[1:0] == 2'b00 && !sticky_i) |-> !round_inc);

  assert_carry_renorm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |=> (sig_o == {1'b1, {(SIG_W-1){1'b0}}} &&
                   exp_o == $past(exp_i) + 1'b1));

  assert_ovf_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (ovf_o == (exp_o == {EXP_W{1'b1}})));
endmodule

bind fp_round_stage fp_round_stage_checker #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_i    (mode_i),
  .sign_i    (sign_i),
  .exp_i     (exp_i),
  .sig_i     (sig_i),
  .sticky_i  (sticky_i),
  .sign_o    (sign_o),
  .exp_o     (exp_o),
  .sig_o     (sig_o),
  .ovf_o     (ovf_o),
  .round_inc (round_inc),
  .tie_seen  (tie_seen),
  .carry_out (carry_out)
);

// File: tb/fp_round_stage_bench.sv
module fp_round_stage_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        sign_i = 1'b0;
  logic [7:0]  exp_i = 8'd1;
  logic [25:0] sig_i = {24'h800000, 2'b00};
  logic        sticky_i = 1'b0;
  logic        sign_o;
  logic [7:0]  exp_o;
  logic [23:0] sig_o;
  logic        ovf_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  fp_round_stage u_fp_round_stage (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sign_i(sign_i),
    .exp_i(exp_i), .sig_i(sig_i), .sticky_i(sticky_i),
    .sign_o(sign_o), .exp_o(exp_o), .sig_o(sig_o), .ovf_o(ovf_o)
  );

  // {mode, sign, exp, sig24, guard, round, sticky, exp_exp, exp_sig, exp_ovf}
  localparam logic [70:0] VECS [0:13] = '{
    {2'd0,1'b0,8'd100,24'hC00001,1'b0,1'b1,1'b1,8'd100,24'hC00001,1'b0}, // R6 guard 0
    {2'd0,1'b0,8'd100,24'hC00001,1'b1,1'b0,1'b1,8'd100,24'hC00002,1'b0}, // R6 above half
    {2'd0,1'b0,8'd100,24'hC00001,1'b1,1'b0,1'b0,8'd100,24'hC00002,1'b0}, // R7 tie odd
    {2'd0,1'b1,8'd100,24'hC00002,1'b1,1'b0,1'b0,8'd100,24'hC00002,1'b0}, // R7 tie even
    {2'd1,1'b0,8'd100,24'hC00001,1'b1,1'b1,1'b1,8'd100,24'hC00001,1'b0}, // R3
    {2'd2,1'b0,8'd100,24'hC00001,1'b0,1'b0,1'b1,8'd100,24'hC00002,1'b0}, // R4 positive
    {2'd2,1'b1,8'd100,24'hC00001,1'b1,1'b1,1'b1,8'd100,24'hC00001,1'b0}, // R4 negative
    {2'd3,1'b1,8'd100,24'hC00001,1'b0,1'b1,1'b0,8'd100,24'hC00002,1'b0}, // R5 negative
    {2'd3,1'b0,8'd100,24'hC00001,1'b1,1'b1,1'b1,8'd100,24'hC00001,1'b0}, // R5 positive
    {2'd2,1'b0,8'd100,24'hC00001,1'b0,1'b0,1'b0,8'd100,24'hC00001,1'b0}, // R8
    {2'd0,1'b0,8'd100,24'hFFFFFF,1'b1,1'b1,1'b0,8'd101,24'h800000,1'b0}, // R9
    {2'd2,1'b0,8'd254,24'hFFFFFF,1'b0,1'b0,1'b1,8'd255,24'h800000,1'b1}, // R10
    {2'd3,1'b1,8'd254,24'hFFFFFF,1'b1,1'b0,1'b0,8'd255,24'h800000,1'b1}, // R10
    {2'd0,1'b0,8'd254,24'hFFFFFF,1'b0,1'b1,1'b1,8'd254,24'hFFFFFF,1'b0}  // R10 none
  };
  localparam int VREQ [0:13] = '{6, 6, 7, 7, 3, 4, 4, 5, 5, 8, 9, 10, 10, 10};

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic s, input logic [7:0] e,
                       input logic [25:0] sg, input logic st);
    @(negedge clk);
    mode_i = m; sign_i = s; exp_i = e; sig_i = sg; sticky_i = st;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {sign_o, exp_o, sig_o, ovf_o}, 34'd0);
    rst_n = 1'b1;

    // table walk; R2 sign passthrough checked as part of each compare
    for (int i = 0; i < 14; i++) begin
      apply(VECS[i][70:69], VECS[i][68], VECS[i][67:60], VECS[i][59:34], VECS[i][33]);
      check($sformatf("R%0d/R2 vec %0d", VREQ[i], i),
            {sign_o, exp_o, sig_o, ovf_o},
            {VECS[i][68], VECS[i][32:25], VECS[i][24:1], VECS[i][0]});
    end

    // R8: exact value untouched in all four modes, negative sign
    for (int m = 0; m < 4; m++) begin
      apply(m[1:0], 1'b1, 8'd37, {24'hABCDEF, 2'b00}, 1'b0);
      check($sformatf("R8 mode %0d", m), {sign_o, exp_o, sig_o, ovf_o},
            {1'b1, 8'd37, 24'hABCDEF, 1'b0});
    end

    // R3: toward zero on negative with all discarded bits set
    apply(2'b01, 1'b1, 8'd200, {24'hFFFFFF, 2'b11}, 1'b1);
    check("R3 neg", {sign_o, exp_o, sig_o, ovf_o}, {1'b1, 8'd200, 24'hFFFFFF, 1'b0});

    // R1: reset asserted mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid", {sign_o, exp_o, sig_o, ovf_o}, 34'd0);
    @(negedge clk);
    rst_n = 1'b1;

    report();
  end
endmodule